// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block is the general register file of a small processor core. It has eight 32-bit registers. Each register can be used as an address or data register at full width. Each one can also be reached as either of its two 16-bit halves, or as either byte of its lower half. The access width is picked afresh on every access. One instruction may therefore update a single byte of a register that the next instruction reads as a long word.

There are two combinational read ports and one write port that updates on the clock edge. Each port carries a 2-bit size code and a 4-bit specifier. Narrow reads come back zero-extended. A narrow write merges into the register and leaves all other bits untouched. Register 7 is also the stack pointer, and a dedicated adjust port moves it by 2 or 4 for the implicit pushes and pops of calls and exception entry. Alongside the adjust port, the block gives the memory address that the stack access should use.

Top module: `mwrf_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all eight registers to zero.
- R2: A read with size code 2'b10 and specifier 4'b0rrr returns all 32 bits of register rrr.
- R3: A read with size code 2'b01 returns bits 31:16 of register spec[2:0] when spec[3]=1 and bits 15:0 when spec[3]=0, zero-extended to 32 bits.
- R4: A read with size code 2'b00 returns bits 7:0 of register spec[2:0] when spec[3]=1 and bits 15:8 when spec[3]=0, zero-extended to 32 bits.
- R5: A long-word write (size 2'b10, spec[3]=0) replaces all 32 bits of the register with `wr_data`.
- R6: A word or byte write takes the low 16 or 8 bits of `wr_data`, places them in the field chosen as in R3/R4, and leaves every other bit of the register unchanged.
- R7: Size code 2'b11, and a long-word access with spec[3]=1, are invalid: such a write changes no register, and such a read returns zero.
- R8: The read ports show the register contents from before the current edge, so a read of a register being written in the same cycle returns the old value.
- R9: With `sp_adj_en`=1 and `sp_adj_pop`=0 (push), register 7 is lowered by 4 (`sp_adj_long`=1) or 2 (`sp_adj_long`=0) at the edge, and `sp_addr` shows register 7 minus that step in the same cycle.
- R10: With `sp_adj_en`=1 and `sp_adj_pop`=1 (pop), register 7 is raised by 4 or 2 at the edge, and `sp_addr` shows the unchanged register 7 in the same cycle.
- R11: When a valid write targets register 7 in the same cycle as an adjustment, only the write takes effect.
- R12: `sp_out` always shows the current contents of register 7, and it changes only through reset, a write to register 7, or an adjustment.
- R13: The two read ports decode their size and specifier independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_spec | input | 4 | Read port 0 specifier |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_spec | input | 4 | Read port 1 specifier |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_size | input | 2 | Write size code |
| wr_spec | input | 4 | Write specifier |
| wr_data | input | 32 | Write data, right-aligned |
| sp_adj_en | input | 1 | Stack pointer adjust request |
| sp_adj_pop | input | 1 | 1 = pop (increment), 0 = push (decrement) |
| sp_adj_long | input | 1 | 1 = step of 4, 0 = step of 2 |
| sp_out | output | 32 | Current stack pointer (register 7) |
| sp_addr | output | 32 | Address for the stack access of this cycle |

## Verification
The assertions take it that reset is held at the first clock edge. They also take it that the size and specifier inputs are at known values whenever reset is low, because the checks on zero-extension and on invalid-size reads look at the read data in every cycle. The stack checks work out the step and the register-7 write hit themselves from the raw port values, and they assume the adjust inputs are stable over the cycle. The stimulus drives every input at the falling edge, from a fully defined random or directed value. It holds reset for the first several cycles and pulses it only as a whole cycle, so none of these assumptions is ever broken.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_NONE = 2'b11
    } acc_size_e;

endpackage

// File: rtl/mwrf_decode.sv
module mwrf_decode #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    localparam int SPEC_W = IDX_W + 1,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic [1:0]        size,
    input  logic [SPEC_W-1:0] spec,
    output logic              valid,
    output logic [IDX_W-1:0]  idx,
    output logic [SH_W-1:0]   lane_shift,
    output logic [DATA_W-1:0] lane_mask
);
    import mwrf_pkg::*;

    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = DATA_W / 4;
    localparam logic [DATA_W-1:0] BYTE_ONES = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [DATA_W-1:0] HALF_ONES = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] FULL_ONES = {DATA_W{1'b1}};

    acc_size_e         sz;
    logic              sel_bit;
    logic [DATA_W-1:0] width_mask;

    assign sz      = acc_size_e'(size);
    assign sel_bit = spec[SPEC_W-1];
    assign idx     = spec[IDX_W-1:0];

    always_comb begin
        valid      = 1'b1;
        lane_shift = '0;
        width_mask = '0;
        case (sz)
            SZ_BYTE: begin
                // selector set: low byte; clear: byte above it
                lane_shift = sel_bit ? SH_W'(0) : SH_W'(BYTE_W);
                width_mask = BYTE_ONES;
            end
            SZ_WORD: begin
                // selector set: extended (upper) half
                lane_shift = sel_bit ? SH_W'(HALF_W) : SH_W'(0);
                width_mask = HALF_ONES;
            end
            SZ_LONG: begin
                valid      = ~sel_bit;
                width_mask = FULL_ONES;
            end
            default: begin
                valid = 1'b0;
            end
        endcase
    end

    assign lane_mask = width_mask << lane_shift;

endmodule

// File: rtl/mwrf_rdport.sv
module mwrf_rdport #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SPEC_W  = IDX_W + 1
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [1:0]                      size,
    input  logic [SPEC_W-1:0]               spec,
    output logic [DATA_W-1:0]               data
);
    localparam int SH_W = $clog2(DATA_W);

    logic              valid;
    logic [IDX_W-1:0]  idx;
    logic [SH_W-1:0]   lane_shift;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] raw;

    mwrf_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
        .size       (size),
        .spec       (spec),
        .valid      (valid),
        .idx        (idx),
        .lane_shift (lane_shift),
        .lane_mask  (lane_mask)
    );

    assign raw  = regs[idx];
    assign data = valid ? ((raw & lane_mask) >> lane_shift) : '0;

endmodule

// File: rtl/mwrf_spadj.sv
module mwrf_spadj #(
    parameter int DATA_W    = 32,
    parameter int STEP_WORD = 2,
    parameter int STEP_LONG = 4
) (
    input  logic              en,
    input  logic              pop,
    input  logic              long_step,
    input  logic [DATA_W-1:0] sp_cur,
    output logic [DATA_W-1:0] sp_next,
    output logic [DATA_W-1:0] sp_addr
);
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] sp_up;
    logic [DATA_W-1:0] sp_down;

    assign step    = long_step ? DATA_W'(STEP_LONG) : DATA_W'(STEP_WORD);
    assign sp_up   = sp_cur + step;
    assign sp_down = sp_cur - step;

    always_comb begin
        sp_next = sp_cur;
        if (en) begin
            sp_next = pop ? sp_up : sp_down;
        end
    end

    // push uses the decremented address, pop uses the address before increment
    assign sp_addr = pop ? sp_cur : sp_down;

endmodule

// File: rtl/mwrf_top.sv
module mwrf_top #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int SP_INDEX = 7,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SPEC_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rd0_size,
    input  logic [SPEC_W-1:0] rd0_spec,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [1:0]        rd1_size,
    input  logic [SPEC_W-1:0] rd1_spec,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic [SPEC_W-1:0] wr_spec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sp_adj_en,
    input  logic              sp_adj_pop,
    input  logic              sp_adj_long,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] sp_addr
);
    localparam int NUM_RD = 2;
    localparam int SH_W   = $clog2(DATA_W);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    // ---------------- read ports ----------------
    logic [1:0]        rd_size_a [NUM_RD];
    logic [SPEC_W-1:0] rd_spec_a [NUM_RD];
    logic [DATA_W-1:0] rd_data_a [NUM_RD];

    assign rd_size_a[0] = rd0_size;
    assign rd_spec_a[0] = rd0_spec;
    assign rd_size_a[1] = rd1_size;
    assign rd_spec_a[1] = rd1_spec;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        mwrf_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
            .regs (st_q.regs),
            .size (rd_size_a[p]),
            .spec (rd_spec_a[p]),
            .data (rd_data_a[p])
        );
    end

    assign rd0_data = rd_data_a[0];
    assign rd1_data = rd_data_a[1];

    // ---------------- write decode ----------------
    logic              wr_valid;
    logic [IDX_W-1:0]  wr_idx;
    logic [SH_W-1:0]   wr_shift;
    logic [DATA_W-1:0] wr_mask;
    logic [DATA_W-1:0] wr_lane;
    logic              wr_hit;
    logic              wr_hits_sp;

    mwrf_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wdec (
        .size       (wr_size),
        .spec       (wr_spec),
        .valid      (wr_valid),
        .idx        (wr_idx),
        .lane_shift (wr_shift),
        .lane_mask  (wr_mask)
    );

    assign wr_lane    = (wr_data << wr_shift) & wr_mask;
    assign wr_hit     = wr_en & wr_valid;
    assign wr_hits_sp = wr_hit & (wr_idx == IDX_W'(SP_INDEX));

    // ---------------- stack pointer ----------------
    logic [DATA_W-1:0] sp_cur;
    logic [DATA_W-1:0] sp_adj_next;
    logic              adj_take;

    assign sp_cur   = st_q.regs[SP_INDEX];
    assign adj_take = sp_adj_en & ~wr_hits_sp;

    mwrf_spadj #(.DATA_W(DATA_W)) u_sp (
        .en        (adj_take),
        .pop       (sp_adj_pop),
        .long_step (sp_adj_long),
        .sp_cur    (sp_cur),
        .sp_next   (sp_adj_next),
        .sp_addr   (sp_addr)
    );

    assign sp_out = sp_cur;

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        st_d.regs[SP_INDEX] = sp_adj_next;
        if (wr_hit) begin
            st_d.regs[wr_idx] = (st_q.regs[wr_idx] & ~wr_mask) | wr_lane;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mwrf_checker.sv
module mwrf_checker #(
    parameter int DATA_W = 32,
    parameter int SPEC_W = 4,
    parameter int SP_INDEX = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        rd0_size,
    input logic [SPEC_W-1:0] rd0_spec,
    input logic [DATA_W-1:0] rd0_data,
    input logic [1:0]        rd1_size,
    input logic [DATA_W-1:0] rd1_data,
    input logic              wr_en,
    input logic [1:0]        wr_size,
    input logic [SPEC_W-1:0] wr_spec,
    input logic [DATA_W-1:0] wr_data,
    input logic              sp_adj_en,
    input logic              sp_adj_pop,
    input logic              sp_adj_long,
    input logic [DATA_W-1:0] sp_out,
    input logic [DATA_W-1:0] sp_addr
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = DATA_W / 4;
    localparam logic [SPEC_W-2:0] SP_SEL = (SPEC_W-1)'(SP_INDEX);

    logic              narrow_size;
    logic              wr_to_sp;
    logic [DATA_W-1:0] step;

    assign narrow_size = (wr_size == 2'b00) || (wr_size == 2'b01);
    assign wr_to_sp = wr_en && (wr_spec[SPEC_W-2:0] == SP_SEL) &&
                      (narrow_size || (wr_size == 2'b10 && !wr_spec[SPEC_W-1]));
    assign step = sp_adj_long ? DATA_W'(4) : DATA_W'(2);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (sp_out == '0));

    assert_word_zext_R3: assert property (@(posedge clk) disable iff (rst)
        (rd1_size == 2'b01) |-> (rd1_data[DATA_W-1:HALF_W] == '0));

    assert_byte_zext_R4: assert property (@(posedge clk) disable iff (rst)
        (rd0_size == 2'b00) |-> (rd0_data[DATA_W-1:BYTE_W] == '0));

    assert_invalid_read_R7: assert property (@(posedge clk) disable iff (rst)
        ((rd0_size == 2'b11) || (rd0_size == 2'b10 && rd0_spec[SPEC_W-1])) |-> (rd0_data == '0));

    assert_push_step_R9: assert property (@(posedge clk) disable iff (rst)
        (sp_adj_en && !sp_adj_pop && !wr_to_sp) |=> (sp_out == $past(sp_out) - $past(step)));

    assert_push_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (sp_adj_en && !sp_adj_pop) |-> (sp_addr == sp_out - step));

    assert_pop_step_R10: assert property (@(posedge clk) disable iff (rst)
        (sp_adj_en && sp_adj_pop && !wr_to_sp) |=> (sp_out == $past(sp_out) + $past(step)));

    assert_pop_addr_R10: assert property (@(posedge clk) disable iff (rst)
        (sp_adj_en && sp_adj_pop) |-> (sp_addr == sp_out));

    assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_size == 2'b10 && wr_spec == {1'b0, SP_SEL}) |=> (sp_out == $past(wr_data)));

    assert_sp_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!sp_adj_en && !wr_to_sp) |=> $stable(sp_out));

endmodule

bind mwrf_top mwrf_checker #(.DATA_W(DATA_W), .SPEC_W(SPEC_W), .SP_INDEX(SP_INDEX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd0_size    (rd0_size),
    .rd0_spec    (rd0_spec),
    .rd0_data    (rd0_data),
    .rd1_size    (rd1_size),
    .rd1_data    (rd1_data),
    .wr_en       (wr_en),
    .wr_size     (wr_size),
    .wr_spec     (wr_spec),
    .wr_data     (wr_data),
    .sp_adj_en   (sp_adj_en),
    .sp_adj_pop  (sp_adj_pop),
    .sp_adj_long (sp_adj_long),
    .sp_out      (sp_out),
    .sp_addr     (sp_addr)
);

// File: tb/sim_mwrf_top.sv
module sim_mwrf_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int RAND_CYC   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rd0_size = '0, rd1_size = '0, wr_size = '0;
    logic [3:0]  rd0_spec = '0, rd1_spec = '0, wr_spec = '0;
    logic [31:0] wr_data = '0;
    logic        wr_en = 1'b0, sp_adj_en = 1'b0, sp_adj_pop = 1'b0, sp_adj_long = 1'b0;
    logic [31:0] rd0_data, rd1_data, sp_out, sp_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] mdl [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    mwrf_top u0 (
        .clk(clk), .rst(rst),
        .rd0_size(rd0_size), .rd0_spec(rd0_spec), .rd0_data(rd0_data),
        .rd1_size(rd1_size), .rd1_spec(rd1_spec), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_size(wr_size), .wr_spec(wr_spec), .wr_data(wr_data),
        .sp_adj_en(sp_adj_en), .sp_adj_pop(sp_adj_pop), .sp_adj_long(sp_adj_long),
        .sp_out(sp_out), .sp_addr(sp_addr)
    );

    function automatic logic [31:0] mread(logic [1:0] sz, logic [3:0] sp);
        int r = int'(sp[2:0]);
        case (sz)
            2'b00:   return sp[3] ? {24'h0, mdl[r][7:0]} : {24'h0, mdl[r][15:8]};
            2'b01:   return sp[3] ? {16'h0, mdl[r][31:16]} : {16'h0, mdl[r][15:0]};
            2'b10:   return sp[3] ? 32'h0 : mdl[r];
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit mvalid(logic [1:0] sz, logic [3:0] sp);
        return (sz == 2'b00) || (sz == 2'b01) || (sz == 2'b10 && !sp[3]);
    endfunction

    function automatic string rtag(logic [1:0] sz, logic [3:0] sp);
        case (sz)
            2'b00:   return "R4";
            2'b01:   return "R3";
            2'b10:   return sp[3] ? "R7" : "R2";
            default: return "R7";
        endcase
    endfunction

    task automatic mwrite(logic [1:0] sz, logic [3:0] sp, logic [31:0] d);
        int r = int'(sp[2:0]);
        case (sz)
            2'b00: if (sp[3]) mdl[r][7:0] = d[7:0]; else mdl[r][15:8] = d[7:0];
            2'b01: if (sp[3]) mdl[r][31:16] = d[15:0]; else mdl[r][15:0] = d[15:0];
            2'b10: if (!sp[3]) mdl[r] = d;
            default: ;
        endcase
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic set_in(logic [1:0] s0, logic [3:0] p0, logic [1:0] s1, logic [3:0] p1,
                          logic we, logic [1:0] ws, logic [3:0] wp, logic [31:0] wd,
                          logic ae, logic apop, logic along);
        rd0_size = s0; rd0_spec = p0; rd1_size = s1; rd1_spec = p1;
        wr_en = we; wr_size = ws; wr_spec = wp; wr_data = wd;
        sp_adj_en = ae; sp_adj_pop = apop; sp_adj_long = along;
    endtask

    // inputs are set at the falling edge; check combinational outputs, then advance one edge
    task automatic step(string tag);
        logic [31:0] dlt;
        bit hit7;
        #1;
        dlt = sp_adj_long ? 32'd4 : 32'd2;
        if (!rst) begin
            chk((tag != "") ? tag : rtag(rd0_size, rd0_spec), rd0_data, mread(rd0_size, rd0_spec));
            chk((tag != "") ? tag : rtag(rd1_size, rd1_spec), rd1_data, mread(rd1_size, rd1_spec));
            chk("R12", sp_out, mdl[7]);
            if (sp_adj_en) begin
                if (sp_adj_pop) chk("R10", sp_addr, mdl[7]);
                else            chk("R9", sp_addr, mdl[7] - dlt);
            end
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 8; i++) mdl[i] = '0;
        end else begin
            hit7 = wr_en && mvalid(wr_size, wr_spec) && (wr_spec[2:0] == 3'd7);
            if (sp_adj_en && !hit7) mdl[7] = sp_adj_pop ? mdl[7] + dlt : mdl[7] - dlt;
            if (wr_en) mwrite(wr_size, wr_spec, wr_data);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 32'hDEAD_0000 | i;
        rst = 1'b1;
        set_in(2'b10, 4'h0, 2'b10, 4'h1, 1'b1, 2'b10, 4'h2, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        step(""); step(""); step("");
        rst = 1'b0;
        // R1: all registers zero after reset
        for (int i = 0; i < 8; i += 2) begin
            set_in(2'b10, 4'(i), 2'b10, 4'(i + 1), 1'b0, 2'b00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
            step("R1");
        end
        // R5: long write then long read
        set_in(2'b10, 4'h3, 2'b10, 4'h3, 1'b1, 2'b10, 4'h3, 32'hA1B2_C3D4, 1'b0, 1'b0, 1'b0);
        step("R8");
        set_in(2'b10, 4'h3, 2'b01, 4'hB, 1'b0, 2'b00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R5");
        // R6: partial writes keep the rest
        set_in(2'b10, 4'h3, 2'b10, 4'h3, 1'b1, 2'b01, 4'hB, 32'hFFFF_1234, 1'b0, 1'b0, 1'b0);
        step("R6");
        set_in(2'b10, 4'h3, 2'b10, 4'h3, 1'b1, 2'b00, 4'hB, 32'hFFFF_FF55, 1'b0, 1'b0, 1'b0);
        step("R6");
        set_in(2'b10, 4'h3, 2'b10, 4'h3, 1'b1, 2'b00, 4'h3, 32'h0000_0066, 1'b0, 1'b0, 1'b0);
        step("R6");
        set_in(2'b10, 4'h3, 2'b01, 4'h3, 1'b1, 2'b01, 4'h3, 32'h0000_BEEF, 1'b0, 1'b0, 1'b0);
        step("R6");
        set_in(2'b10, 4'h3, 2'b00, 4'h3, 1'b0, 2'b00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R6");
        // R8: same-cycle read returns old value
        set_in(2'b10, 4'h2, 2'b00, 4'hA, 1'b1, 2'b10, 4'h2, 32'h1357_9BDF, 1'b0, 1'b0, 1'b0);
        step("R8");
        set_in(2'b10, 4'h2, 2'b00, 4'hA, 1'b0, 2'b00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R8");
        // R7: invalid writes have no effect, invalid reads give zero
        set_in(2'b11, 4'h1, 2'b10, 4'h9, 1'b1, 2'b11, 4'h1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        step("R7");
        set_in(2'b10, 4'h1, 2'b10, 4'h9, 1'b1, 2'b10, 4'h9, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
        step("R7");
        set_in(2'b10, 4'h1, 2'b01, 4'h9, 1'b0, 2'b00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R7");
        // R9: push long and word from zero
        set_in(2'b10, 4'h7, 2'b01, 4'h7, 1'b0, 2'b00, 4'h0, 32'h0, 1'b1, 1'b0, 1'b1);
        step("R9");
        set_in(2'b10, 4'h7, 2'b01, 4'hF, 1'b0, 2'b00, 4'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        step("R9");
        // R10: pops
        set_in(2'b10, 4'h7, 2'b10, 4'h7, 1'b0, 2'b00, 4'h0, 32'h0, 1'b1, 1'b1, 1'b0);
        step("R10");
        set_in(2'b10, 4'h7, 2'b10, 4'h7, 1'b0, 2'b00, 4'h0, 32'h0, 1'b1, 1'b1, 1'b1);
        step("R10");
        // R11: explicit write beats adjust, long and byte
        set_in(2'b10, 4'h7, 2'b10, 4'h7, 1'b1, 2'b10, 4'h7, 32'h0000_1000, 1'b1, 1'b0, 1'b1);
        step("R11");
        set_in(2'b10, 4'h7, 2'b10, 4'h7, 1'b1, 2'b00, 4'hF, 32'h0000_00AA, 1'b1, 1'b1, 1'b1);
        step("R11");
        set_in(2'b10, 4'h7, 2'b00, 4'hF, 1'b0, 2'b00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R11");
        // R13: ports decode independently
        set_in(2'b10, 4'h3, 2'b00, 4'h2, 1'b0, 2'b00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R13");
        set_in(2'b01, 4'hB, 2'b10, 4'h2, 1'b0, 2'b00, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
        step("R13");
        // random mixed-width traffic with occasional reset (R1..R13)
        for (int c = 0; c < RAND_CYC; c++) begin
            rst = ($urandom_range(0, 299) == 0);
            set_in(2'($urandom), 4'($urandom), 2'($urandom), 4'($urandom),
                   1'($urandom), 2'($urandom), 4'($urandom), $urandom,
                   ($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom));
            step("");
        end
        rst = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule